// File: doc/BRIEF.md
# Flash Byte-Page Program Sequencer

This block is the command front end of a parallel NOR flash working in byte-wide mode. Bus write cycles arrive as an address, a data byte and a write strobe. The block looks for two fast-program commands. The two-byte command takes one setup write and then two data writes. The four-byte command takes one setup write and then four data writes. Each data write puts its byte into a small page register. All bytes of one command must lie in a single naturally aligned page. Once the final byte has been taken, the block gives the program/erase controller one start pulse, together with the aligned base address, the assembled page and a size flag.

Once a program has started, the block stays engaged until the controller signals completion. While engaged, it ignores any new program sequence. It does accept a suspend command, and while suspended it accepts a resume command. Each of these produces a one-cycle request toward the controller. None of these commands needs a raised-voltage protect or acceleration input, and the block has no such pin.

Top module: `page_prog_seq`

## Requirements
- R1: After reset, `start`, `seq_err`, `suspend_req`, `resume_req` and `suspended` are 0, and `pg_data` is all ones.
- R2: In idle, a write of `CMD_DBL` followed by two data writes in the same 2-byte page gives `start`=1 in the cycle after the third write. At that pulse, `pg_len`=0 and `pg_addr` is the byte address with bit 0 cleared.
- R3: In idle, a write of `CMD_QUAD` followed by four data writes in the same 4-byte page gives `start`=1 in the cycle after the fifth write. At that pulse, `pg_len`=1 and `pg_addr` is the byte address with bits 1:0 cleared.
- R4: `start` stays 0 after the setup write and after every data write except the last one.
- R5: Each byte goes to lane `pg_data[8*k+7:8*k]`. The lane number k is address bit 0 for the two-byte command and address bits 1:0 for the four-byte command, so bytes may arrive in any order. Every lane the command does not write reads 8'hFF.
- R6: A data write whose page differs from the page of the first data write gives `seq_err`=1 for one cycle. The sequence is then dropped with no `start`, and the next write is treated as a setup write.
- R7: A data write to a lane already written in the same sequence is handled the same way as in R6: error pulse, no `start`, return to idle.
- R8: In idle, a setup write of any value other than `CMD_DBL` or `CMD_QUAD` gives a one-cycle `seq_err` and the block stays idle.
- R9: From `start` until `ctl_done`, program setup and data writes produce neither `start` nor `seq_err`.
- R10: While a program is running, a write of `CMD_SUSP` gives `suspend_req`=1 for one cycle, and `suspended` goes to 1 in that same cycle. A repeated suspend while suspended produces no new request.
- R11: A write of `CMD_RES` while running but not suspended is ignored. While suspended, it gives `resume_req`=1 for one cycle and `suspended` returns to 0.
- R12: `ctl_done` while running returns the block to idle, and a new program sequence is then accepted.
- R13: `start` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| ctl_done | input | 1 | Controller finished the running program |
| start | output | 1 | One-cycle launch pulse to the controller |
| pg_addr | output | AW | Aligned base address of the page |
| pg_data | output | 32 | Assembled page, lane k in bits 8k+7:8k |
| pg_len | output | 1 | 0 for a two-byte page, 1 for a four-byte page |
| seq_err | output | 1 | One-cycle pulse on a rejected write |
| suspend_req | output | 1 | One-cycle suspend request |
| resume_req | output | 1 | One-cycle resume request |
| suspended | output | 1 | Program currently held in suspend |

## Verification
The properties assume that `ctl_done` is raised only while a launched program is running, and never during suspend. They also assume that each bus write lasts exactly one clock with the strobe high. The bench always drives each write for a single cycle with an idle cycle after it. It raises `ctl_done` only after a `start` pulse and once any suspend has been resumed, so the controller-side handshake never goes outside what the properties expect.

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
  parameter int AW = 22,
  parameter logic [7:0] CMD_DBL  = 8'h50,
  parameter logic [7:0] CMD_QUAD = 8'h56,
  parameter logic [7:0] CMD_SUSP = 8'hB0,
  parameter logic [7:0] CMD_RES  = 8'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          ctl_done,
  output logic          start,
  output logic [AW-1:0] pg_addr,
  output logic [31:0]   pg_data,
  output logic          pg_len,
  output logic          seq_err,
  output logic          suspend_req,
  output logic          resume_req,
  output logic          suspended
);

  typedef enum logic [1:0] {S_IDLE, S_COLL, S_RUN, S_HOLD} st_t;

  st_t           st;
  logic          quad;
  logic [1:0]    cnt;
  logic [3:0]    filled;
  logic [AW-1:0] base;
  logic [31:0]   page_q;

  wire [1:0] slot     = quad ? wr_addr[1:0] : {1'b0, wr_addr[0]};
  wire       first    = (cnt == 2'd0);
  wire       last     = (cnt == (quad ? 2'd3 : 2'd1));
  wire       in_page  = quad ? (wr_addr[AW-1:2] == base[AW-1:2])
                             : (wr_addr[AW-1:1] == base[AW-1:1]);
  wire       accept   = first || (in_page && !filled[slot]);
  wire [AW-1:0] aligned = quad ? {wr_addr[AW-1:2], 2'b00}
                               : {wr_addr[AW-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      quad        <= 1'b0;
      cnt         <= '0;
      filled      <= '0;
      base        <= '0;
      page_q      <= '1;
      start       <= 1'b0;
      seq_err     <= 1'b0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
    end else begin
      start       <= 1'b0;
      seq_err     <= 1'b0;
      suspend_req <= 1'b0;
      resume_req  <= 1'b0;
      unique case (st)
        S_IDLE:
          if (wr_en) begin
            if (wr_data == CMD_DBL || wr_data == CMD_QUAD) begin
              st     <= S_COLL;
              quad   <= (wr_data == CMD_QUAD);
              cnt    <= '0;
              filled <= '0;
              page_q <= '1;
            end else begin
              seq_err <= 1'b1;
            end
          end
        S_COLL:
          if (wr_en) begin
            if (!accept) begin
              seq_err <= 1'b1;
              st      <= S_IDLE;
            end else begin
              page_q[{slot, 3'b000} +: 8] <= wr_data;
              filled[slot] <= 1'b1;
              if (first) base <= aligned;
              if (last) begin
                start <= 1'b1;
                st    <= S_RUN;
              end else begin
                cnt <= cnt + 2'd1;
              end
            end
          end
        S_RUN:
          if (ctl_done) begin
            st <= S_IDLE;
          end else if (wr_en && wr_data == CMD_SUSP) begin
            st          <= S_HOLD;
            suspend_req <= 1'b1;
          end
        S_HOLD:
          if (wr_en && wr_data == CMD_RES) begin
            st         <= S_RUN;
            resume_req <= 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pg_addr   = base;
  assign pg_data   = page_q;
  assign pg_len    = quad;
  assign suspended = (st == S_HOLD);

endmodule

// File: rtl/page_prog_seq_chk.sv
module page_prog_seq_chk #(
  parameter int AW = 22
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          seq_err,
  input logic          suspend_req,
  input logic          resume_req,
  input logic          suspended,
  input logic          pg_len,
  input logic [AW-1:0] pg_addr
);

  // R13
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  // R6
  start_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && seq_err));

  // R2
  dbl_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !pg_len) |-> !pg_addr[0]);

  // R3
  quad_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && pg_len) |-> (pg_addr[1:0] == 2'b00));

  // R10
  susp_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> suspend_req);

  // R10
  susp_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> suspended);

  // R11
  res_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> (!suspended && $past(suspended)));

endmodule

bind page_prog_seq page_prog_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .seq_err(seq_err),
  .suspend_req(suspend_req), .resume_req(resume_req),
  .suspended(suspended), .pg_len(pg_len), .pg_addr(pg_addr)
);

// File: tb/page_prog_seq_test.sv
`timescale 1ns/1ps
module page_prog_seq_test;
  localparam int AW = 22;
  localparam logic [7:0] DBL = 8'h50, QUAD = 8'h56, SUSP = 8'hB0, RES = 8'h30;

  logic clk = 0, rst_n = 0, wr_en = 0, ctl_done = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic start, pg_len, seq_err, suspend_req, resume_req, suspended;
  logic [AW-1:0] pg_addr;
  logic [31:0] pg_data;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  page_prog_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctl_done(ctl_done), .start(start),
    .pg_addr(pg_addr), .pg_data(pg_data), .pg_len(pg_len),
    .seq_err(seq_err), .suspend_req(suspend_req),
    .resume_req(resume_req), .suspended(suspended)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic finish_prog();
    @(negedge clk); ctl_done = 1;
    @(negedge clk); ctl_done = 0;
  endtask

  task automatic t_reset();
    chk(start == 0 && seq_err == 0, "R1 start/err", {start, seq_err}, 0);
    chk(suspend_req == 0 && resume_req == 0 && suspended == 0, "R1 suspend",
        {suspend_req, resume_req, suspended}, 0);
    chk(pg_data == 32'hFFFF_FFFF, "R1 page", pg_data, 32'hFFFF_FFFF);
  endtask

  task automatic t_double();
    bus_write('0, DBL);
    chk(start == 0, "R4 after setup", start, 0);
    bus_write(22'h1235, 8'hAB);
    chk(start == 0, "R4 after first byte", start, 0);
    bus_write(22'h1234, 8'hCD);
    chk(start == 1, "R2 start", start, 1);
    chk(pg_len == 0, "R2 len", pg_len, 0);
    chk(pg_addr == 22'h1234, "R2 addr", pg_addr, 22'h1234);
    chk(pg_data == 32'hFFFF_ABCD, "R5 double lanes", pg_data, 32'hFFFF_ABCD);
    @(negedge clk);
    chk(start == 0, "R13 single pulse", start, 0);
    finish_prog();
  endtask

  task automatic t_quad();
    bus_write('0, QUAD);
    bus_write(22'h2002, 8'h11);
    chk(start == 0, "R4 quad 1", start, 0);
    bus_write(22'h2000, 8'h22);
    chk(start == 0, "R4 quad 2", start, 0);
    bus_write(22'h2003, 8'h33);
    chk(start == 0, "R4 quad 3", start, 0);
    bus_write(22'h2001, 8'h44);
    chk(start == 1, "R3 start", start, 1);
    chk(pg_len == 1, "R3 len", pg_len, 1);
    chk(pg_addr == 22'h2000, "R3 addr", pg_addr, 22'h2000);
    chk(pg_data == 32'h3311_4422, "R5 quad order", pg_data, 32'h3311_4422);
    finish_prog();
  endtask

  task automatic t_page_err();
    bus_write('0, DBL);
    bus_write(22'h0100, 8'h01);
    bus_write(22'h0102, 8'h02);
    chk(seq_err == 1 && start == 0, "R6 double page", {seq_err, start}, 2'b10);
    @(negedge clk);
    chk(seq_err == 0, "R6 one cycle", seq_err, 0);
    bus_write('0, QUAD);
    bus_write(22'h0104, 8'h01);
    bus_write(22'h0108, 8'h02);
    chk(seq_err == 1 && start == 0, "R6 quad page", {seq_err, start}, 2'b10);
    bus_write('0, DBL);
    chk(seq_err == 0, "R6 back to idle", seq_err, 0);
    bus_write(22'h0040, 8'h5A);
    bus_write(22'h0041, 8'hA5);
    chk(start == 1, "R6 next sequence", start, 1);
    finish_prog();
  endtask

  task automatic t_dup();
    bus_write('0, QUAD);
    bus_write(22'h0301, 8'h10);
    bus_write(22'h0301, 8'h20);
    chk(seq_err == 1 && start == 0, "R7 duplicate lane", {seq_err, start}, 2'b10);
  endtask

  task automatic t_bad_setup();
    bus_write('0, 8'h77);
    chk(seq_err == 1, "R8 unknown setup", seq_err, 1);
    bus_write('0, DBL);
    chk(seq_err == 0, "R8 still idle", seq_err, 0);
    bus_write(22'h0600, 8'h01);
    bus_write(22'h0601, 8'h02);
    chk(start == 1, "R8 recovered", start, 1);
    finish_prog();
  endtask

  task automatic t_busy();
    bus_write('0, DBL);
    bus_write(22'h0500, 8'h01);
    bus_write(22'h0501, 8'h02);
    chk(start == 1, "R12 launch", start, 1);
    bus_write('0, DBL);
    bus_write(22'h0500, 8'h09);
    bus_write(22'h0501, 8'h08);
    chk(start == 0 && seq_err == 0, "R9 busy ignores program", {start, seq_err}, 0);
    chk(pg_data[15:0] == 16'h0201, "R9 page kept", pg_data[15:0], 16'h0201);
    bus_write('0, RES);
    chk(resume_req == 0 && suspended == 0, "R11 resume while running", {resume_req, suspended}, 0);
    bus_write('0, SUSP);
    chk(suspend_req == 1 && suspended == 1, "R10 suspend", {suspend_req, suspended}, 2'b11);
    @(negedge clk);
    chk(suspend_req == 0 && suspended == 1, "R10 pulse ends", {suspend_req, suspended}, 2'b01);
    bus_write('0, SUSP);
    chk(suspend_req == 0, "R10 repeat suspend", suspend_req, 0);
    bus_write('0, RES);
    chk(resume_req == 1 && suspended == 0, "R11 resume", {resume_req, suspended}, 2'b10);
    finish_prog();
    bus_write('0, QUAD);
    bus_write(22'h0700, 8'hA0);
    bus_write(22'h0701, 8'hA1);
    bus_write(22'h0702, 8'hA2);
    bus_write(22'h0703, 8'hA3);
    chk(start == 1, "R12 idle after done", start, 1);
    finish_prog();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_double();
    t_quad();
    t_page_err();
    t_dup();
    t_bad_setup();
    t_busy();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule